// File: doc/BRIEF.md
# Message-Signalled Interrupt Controller

This block gathers a set of level-sensitive device interrupt lines into a pending register and a request register. It tells the CPU about an interrupt by writing one 32-bit word on an outbound master port, not by driving a wire. Both the address and the data of that write come from one programmable target register. The low five bits of the target are the data word. The target with those five bits cleared is the address.

Software reaches five 32-bit registers through a small register port. The port takes a word index and four byte-lane enables, so each access covers one to four bytes. Byte lanes are big-endian: lane enable 0 covers the most significant byte. A mask register selects which lines may raise messages. A control bit reports a bus error and, while it is set, stops all messages. The pending register clears itself on any read and on any write. While a message waits for the bus, each line can hold one further message. A second arrival on that line merges with the one already held.

Top module: `msg_irq_ctrl`

## Requirements
- R1: After reset the control bit, mask, request and pending registers read zero. The target register reads CPU_BASE+3. msg_valid and bad_mask are low.
- R2: Each clock edge that samples line n high sets pending bit n, whatever the mask holds. A low line leaves the pending register unchanged.
- R3: Each clock edge that samples line n high while mask bit n is set also sets request bit n. Request bits clear only on reset, and writes to the request register have no effect.
- R4: When an edge samples a low-to-high change on an unmasked line and the bus-error bit is clear, msg_valid rises after the second clock edge that follows. The message then carries msg_addr = target & 0xFFFFFFE0 and msg_data = target & 0x1F.
- R5: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold steady. Only one message is in flight at a time.
- R6: Each line holds at most one queued message behind the one in flight. Any number of rises on a line while its message is queued produce just one further message.
- R7: While control bit 0 (bus error) is set, rises are not queued and no message starts. Pending and request bits still update.
- R8: A read of the pending register returns its value from before the access and then clears it. A bit that its line sets in the same cycle as the read survives the clear.
- R9: A write to the pending register clears it, whatever the data or byte enables.
- R10: A read of the control register returns only bit 0. All other bits read zero, even after all-ones has been written.
- R11: A write changes only the enabled bytes of the control, target and mask registers. reg_be[0] covers bits 31:24 and reg_be[3] covers bits 7:0.
- R12: bad_mask sets and stays set until reset when a mask write produces a value that has a bit at index NUM_LINES or above and is not all-ones.
- R13: Word indices are 0 for control, 1 for target, 2 for mask, 3 for request and 4 for pending. Other indices read zero. reg_rvalid pulses, with reg_rdata, one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Device interrupt lines, level sampled |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Register word index |
| reg_be | input | 4 | Byte-lane enables, bit 0 = most significant byte |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the request |
| msg_valid | output | 1 | Outbound write valid |
| msg_ready | input | 1 | Outbound write accepted |
| msg_addr | output | 32 | Outbound write address |
| msg_data | output | 32 | Outbound write data |
| bad_mask | output | 1 | Sticky invalid-mask flag |

## Verification
The checks on the outbound port assume the receiver leaves msg_ready alone only as a handshake input. msg_valid and the message fields may change only after a transfer. The bench therefore holds msg_ready low for many cycles and raises it later, which tests that the message holds steady. The pending and request checks assume each interrupt line is an ordinary synchronous level. The bench drives every line and every register access on the falling clock edge. It holds each access strobe for exactly one cycle, so every sampled value is unambiguous.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;

    localparam int WORD_W    = 32;
    localparam int LANES     = WORD_W / 8;
    localparam int MSG_LOW_W = 5;
    localparam int BERR_BIT  = 0;
    localparam int SEL_W     = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 3'd0,
        SEL_TGT  = 3'd1,
        SEL_MASK = 3'd2,
        SEL_REQ  = 3'd3,
        SEL_PEND = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } irq_msg_t;

    // Bit mask selected by big-endian byte enables: lane 0 is the top byte.
    function automatic logic [WORD_W-1:0] lane_bits(input logic [LANES-1:0] be);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) m[WORD_W-1-8*i -: 8] = 8'hFF;
        end
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_v,
                                                     input logic [WORD_W-1:0] new_v,
                                                     input logic [LANES-1:0]  be);
        logic [WORD_W-1:0] m;
        m = lane_bits(be);
        return (old_v & ~m) | (new_v & m);
    endfunction

    // Set of implemented interrupt line bits.
    function automatic logic [WORD_W-1:0] line_set(input int n);
        logic [WORD_W-1:0] s;
        s = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < n) s[i] = 1'b1;
        end
        return s;
    endfunction

    // Outbound write: aligned address plus low bits as data.
    function automatic irq_msg_t build_msg(input logic [WORD_W-1:0] target);
        irq_msg_t m;
        m.addr = {target[WORD_W-1:MSG_LOW_W], {MSG_LOW_W{1'b0}}};
        m.data = {{(WORD_W-MSG_LOW_W){1'b0}}, target[MSG_LOW_W-1:0]};
        return m;
    endfunction

endpackage

// File: rtl/msg_irq_regs.sv
module msg_irq_regs
    import msg_irq_pkg::*;
#(
    parameter int                NUM_LINES = 16,
    parameter int                REG_AW    = 6,
    parameter logic [WORD_W-1:0] CPU_BASE  = 32'hFFFA_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_req,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [LANES-1:0]     reg_be,
    input  logic [WORD_W-1:0]    reg_wdata,
    input  logic [NUM_LINES-1:0] pend_in,
    input  logic [NUM_LINES-1:0] req_in,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 reg_rvalid,
    output logic [NUM_LINES-1:0] mask_o,
    output logic                 berr_o,
    output logic [WORD_W-1:0]    target_o,
    output logic                 pend_clr_o,
    output logic                 bad_mask_o
);

    localparam logic [WORD_W-1:0] IMPL_SET = line_set(NUM_LINES);

    logic              berr_q;
    logic [WORD_W-1:0] target_q;
    logic [WORD_W-1:0] mask_q;
    logic              bad_q;

    reg_sel_e          sel;
    logic              hit;
    logic              wr_hit;
    logic              rd_hit;
    logic [WORD_W-1:0] pend_w;
    logic [WORD_W-1:0] req_w;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] ctrl_new;
    logic [WORD_W-1:0] mask_new;

    assign sel    = reg_sel_e'(reg_addr[SEL_W-1:0]);
    assign hit    = (reg_addr[REG_AW-1:SEL_W] == '0);
    assign wr_hit = reg_req && reg_we && hit;
    assign rd_hit = reg_req && !reg_we && hit;

    always_comb begin
        pend_w = '0;
        req_w  = '0;
        pend_w[NUM_LINES-1:0] = pend_in;
        req_w[NUM_LINES-1:0]  = req_in;
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CTRL: rd_mux[BERR_BIT] = berr_q;
            SEL_TGT:  rd_mux = target_q;
            SEL_MASK: rd_mux = mask_q;
            SEL_REQ:  rd_mux = req_w;
            SEL_PEND: rd_mux = pend_w;
            default:  rd_mux = '0;
        endcase
    end

    always_comb begin
        ctrl_new = '0;
        ctrl_new[BERR_BIT] = berr_q;
        ctrl_new = lane_merge(ctrl_new, reg_wdata, reg_be);
        mask_new = lane_merge(mask_q, reg_wdata, reg_be);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            berr_q     <= 1'b0;
            target_q   <= CPU_BASE + 32'd3;
            mask_q     <= '0;
            bad_q      <= 1'b0;
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_req && !reg_we;
            if (reg_req && !reg_we) begin
                reg_rdata <= rd_hit ? rd_mux : '0;
            end
            if (wr_hit) begin
                case (sel)
                    SEL_CTRL: berr_q   <= ctrl_new[BERR_BIT];
                    SEL_TGT:  target_q <= lane_merge(target_q, reg_wdata, reg_be);
                    SEL_MASK: begin
                        mask_q <= mask_new;
                        if (((mask_new & ~IMPL_SET) != '0) && (mask_new != '1)) begin
                            bad_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pend_clr_o = reg_req && hit && (sel == SEL_PEND);
    assign mask_o     = mask_q[NUM_LINES-1:0];
    assign berr_o     = berr_q;
    assign target_o   = target_q;
    assign bad_mask_o = bad_q;

endmodule

// File: rtl/msg_irq_capture.sv
module msg_irq_capture #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] mask,
    input  logic                 berr,
    input  logic                 pend_clr,
    input  logic [NUM_LINES-1:0] take,
    output logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] req,
    output logic [NUM_LINES-1:0] queued
);

    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] arrive;

    assign rise   = irq_in & ~prev_q;
    assign arrive = rise & mask & {NUM_LINES{!berr}};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend   <= '0;
            req    <= '0;
            queued <= '0;
        end else begin
            prev_q <= irq_in;
            pend   <= (pend & {NUM_LINES{!pend_clr}}) | irq_in;
            req    <= req | (irq_in & mask);
            queued <= (queued & ~take) | arrive;
        end
    end

endmodule

// File: rtl/msg_irq_sender.sv
module msg_irq_sender
    import msg_irq_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] queued,
    input  logic                 berr,
    input  logic [WORD_W-1:0]    target,
    output logic [NUM_LINES-1:0] take,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [WORD_W-1:0]    msg_addr,
    output logic [WORD_W-1:0]    msg_data
);

    logic [NUM_LINES-1:0] cand;
    logic [NUM_LINES:0]   seen;
    irq_msg_t             msg_q;
    logic                 launch;

    assign launch  = !msg_valid && !berr && (queued != '0);
    assign cand    = launch ? queued : '0;
    assign seen[0] = 1'b0;

    // Lowest-index line wins the launch slot.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_pick
        assign take[g]   = cand[g] & ~seen[g];
        assign seen[g+1] = seen[g] | cand[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_q     <= '0;
        end else if (msg_valid) begin
            if (msg_ready) msg_valid <= 1'b0;
        end else if (launch) begin
            msg_valid <= 1'b1;
            msg_q     <= build_msg(target);
        end
    end

    assign msg_addr = msg_q.addr;
    assign msg_data = msg_q.data;

endmodule

// File: rtl/msg_irq_ctrl.sv
module msg_irq_ctrl
    import msg_irq_pkg::*;
#(
    parameter int                NUM_LINES = 16,
    parameter int                REG_AW    = 6,
    parameter logic [WORD_W-1:0] CPU_BASE  = 32'hFFFA_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_req,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [LANES-1:0]     reg_be,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 reg_rvalid,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [WORD_W-1:0]    msg_addr,
    output logic [WORD_W-1:0]    msg_data,
    output logic                 bad_mask
);

    logic [NUM_LINES-1:0] mask_w;
    logic [NUM_LINES-1:0] pend_w;
    logic [NUM_LINES-1:0] req_w;
    logic [NUM_LINES-1:0] queued_w;
    logic [NUM_LINES-1:0] take_w;
    logic                 berr_w;
    logic                 pend_clr_w;
    logic [WORD_W-1:0]    target_w;

    msg_irq_regs #(
        .NUM_LINES (NUM_LINES),
        .REG_AW    (REG_AW),
        .CPU_BASE  (CPU_BASE)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_req    (reg_req),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_be     (reg_be),
        .reg_wdata  (reg_wdata),
        .pend_in    (pend_w),
        .req_in     (req_w),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .mask_o     (mask_w),
        .berr_o     (berr_w),
        .target_o   (target_w),
        .pend_clr_o (pend_clr_w),
        .bad_mask_o (bad_mask)
    );

    msg_irq_capture #(
        .NUM_LINES (NUM_LINES)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .mask     (mask_w),
        .berr     (berr_w),
        .pend_clr (pend_clr_w),
        .take     (take_w),
        .pend     (pend_w),
        .req      (req_w),
        .queued   (queued_w)
    );

    msg_irq_sender #(
        .NUM_LINES (NUM_LINES)
    ) u_sender (
        .clk       (clk),
        .rst       (rst),
        .queued    (queued_w),
        .berr      (berr_w),
        .target    (target_w),
        .take      (take_w),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

endmodule

// File: rtl/msg_irq_chk.sv
module msg_irq_chk #(
    parameter int NUM_LINES = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] irq_in,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] req,
    input logic                 berr,
    input logic                 reg_req,
    input logic                 reg_we,
    input logic                 reg_rvalid,
    input logic                 msg_valid,
    input logic                 msg_ready,
    input logic [31:0]          msg_addr,
    input logic [31:0]          msg_data,
    input logic                 bad_mask
);

    AST_PEND_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(irq_in)) == $past(irq_in))); // R2

    AST_REQ_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((req & $past(req)) == $past(req))); // R3

    AST_MSG_SHAPE: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr[4:0] == 5'd0) && (msg_data[31:5] == 27'd0)); // R4

    AST_MSG_HELD: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R5

    AST_NO_START_IN_BERR: assert property (@(posedge clk) disable iff (rst)
        (!msg_valid && berr) |=> !msg_valid); // R7

    AST_BAD_MASK_STICKY: assert property (@(posedge clk) disable iff (rst)
        bad_mask |=> bad_mask); // R12

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_we) |=> reg_rvalid); // R13

endmodule

bind msg_irq_ctrl msg_irq_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .pend       (pend_w),
    .req        (req_w),
    .berr       (berr_w),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_rvalid (reg_rvalid),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data),
    .bad_mask   (bad_mask)
);

// File: tb/msg_irq_ctrl_tb.sv
module msg_irq_ctrl_tb;

    localparam int          NL     = 16;
    localparam int          AW     = 6;
    localparam logic [31:0] BASE   = 32'hFFFA_0000;
    localparam logic [5:0]  A_CTRL = 6'd0;
    localparam logic [5:0]  A_TGT  = 6'd1;
    localparam logic [5:0]  A_MASK = 6'd2;
    localparam logic [5:0]  A_REQ  = 6'd3;
    localparam logic [5:0]  A_PEND = 6'd4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] irq_in = '0;
    logic          reg_req = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [3:0]    reg_be = 4'hF;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          reg_rvalid;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [31:0]   msg_addr;
    logic [31:0]   msg_data;
    logic          bad_mask;

    int checks = 0;
    int errors = 0;
    int msg_count = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    msg_irq_ctrl #(.NUM_LINES(NL), .REG_AW(AW), .CPU_BASE(BASE)) u_dut (
        .clk, .rst, .irq_in, .reg_req, .reg_we, .reg_addr, .reg_be, .reg_wdata,
        .reg_rdata, .reg_rvalid, .msg_valid, .msg_ready, .msg_addr, .msg_data, .bad_mask
    );

    always @(posedge clk) begin
        if (!rst && msg_valid && msg_ready) msg_count <= msg_count + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a; reg_be = 4'hF;
        @(negedge clk);
        reg_req = 1'b0;
        d = reg_valid_data();
    endtask

    function automatic logic [31:0] reg_valid_data();
        return reg_rvalid ? reg_rdata : 32'hDEAD_BEEF;
    endfunction

    task automatic pulse(input int line);
        irq_in[line] = 1'b1;
        @(negedge clk);
        irq_in[line] = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(A_TGT, v);  chk(v == BASE + 3, "R1 target", v, BASE + 3);
        rd(A_MASK, v); chk(v == 0, "R1 mask", v, 0);
        rd(A_REQ, v);  chk(v == 0, "R1 req", v, 0);
        rd(A_PEND, v); chk(v == 0, "R1 pend", v, 0);
        rd(6'd7, v);   chk(v == 0, "R13 unmapped index", v, 0);
        chk(!msg_valid && !bad_mask, "R1 outputs", {30'd0, msg_valid, bad_mask}, 0);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        pulse(3);
        rd(A_PEND, v); chk(v == 32'h8, "R2 pend set unmasked", v, 32'h8);
        rd(A_PEND, v); chk(v == 0, "R8 read clears pend", v, 0);
        rd(A_REQ, v);  chk(v == 0, "R3 masked line no req", v, 0);
        chk(msg_count == 0, "R4 no msg when masked", msg_count, 0);
        pulse(5);
        wr(A_PEND, 32'h0, 4'b0001);
        rd(A_PEND, v); chk(v == 0, "R9 write clears pend", v, 0);
    endtask

    task automatic t_message();
        logic [31:0] v;
        int c0;
        wr(A_TGT, 32'h1234_5677, 4'hF);
        wr(A_MASK, 32'h0000_0011, 4'hF);
        c0 = msg_count;
        irq_in[4] = 1'b1;
        @(negedge clk);
        irq_in[4] = 1'b0;
        chk(!msg_valid, "R4 not valid after first edge", {31'd0, msg_valid}, 0);
        @(negedge clk);
        chk(msg_valid, "R4 valid after second edge", {31'd0, msg_valid}, 1);
        chk(msg_addr == 32'h1234_5660, "R4 msg addr", msg_addr, 32'h1234_5660);
        chk(msg_data == 32'h17, "R4 msg data", msg_data, 32'h17);
        idle(3);
        chk(msg_count == c0 + 1, "R4 one msg", msg_count, c0 + 1);
        rd(A_REQ, v); chk(v == 32'h10, "R3 req set", v, 32'h10);
        wr(A_REQ, 32'hFFFF_FFFF, 4'hF);
        rd(A_REQ, v); chk(v == 32'h10, "R3 req write ignored", v, 32'h10);
    endtask

    task automatic t_backpressure();
        logic [31:0] a0;
        int c0;
        c0 = msg_count;
        msg_ready = 1'b0;
        pulse(0);
        chk(msg_valid, "R5 valid pending ready", {31'd0, msg_valid}, 1);
        a0 = msg_addr;
        for (int k = 0; k < 3; k++) pulse(0);
        pulse(4);
        chk(msg_valid && msg_addr == a0, "R5 held while not ready", msg_addr, a0);
        msg_ready = 1'b1;
        idle(12);
        chk(msg_count == c0 + 3, "R6 merged queue count", msg_count, c0 + 3);
    endtask

    task automatic t_bus_error();
        logic [31:0] v;
        int c0;
        wr(A_CTRL, 32'hFFFF_FFFF, 4'hF);
        rd(A_CTRL, v); chk(v == 32'h1, "R10 ctrl reads bit 0 only", v, 32'h1);
        wr(A_PEND, 32'h0, 4'hF);
        c0 = msg_count;
        pulse(4);
        idle(4);
        chk(msg_count == c0, "R7 no msg in bus error", msg_count, c0);
        rd(A_PEND, v); chk(v == 32'h10, "R7 pend still set", v, 32'h10);
        wr(A_CTRL, 32'h0, 4'hF);
        idle(5);
        chk(msg_count == c0, "R7 nothing queued during bus error", msg_count, c0);
        rd(A_CTRL, v); chk(v == 0, "R10 ctrl cleared", v, 0);
    endtask

    task automatic t_lanes();
        logic [31:0] v;
        wr(A_TGT, 32'h0000_00AB, 4'b1000);
        rd(A_TGT, v); chk(v == 32'h1234_56AB, "R11 low lane", v, 32'h1234_56AB);
        wr(A_TGT, 32'hCD00_0000, 4'b0001);
        rd(A_TGT, v); chk(v == 32'hCD34_56AB, "R11 high lane", v, 32'hCD34_56AB);
        wr(A_CTRL, 32'hFFFF_FF00, 4'b0111);
        rd(A_CTRL, v); chk(v == 0, "R11 ctrl lane not enabled", v, 0);
    endtask

    task automatic t_mask_flag();
        logic [31:0] v;
        wr(A_MASK, 32'hFFFF_FFFF, 4'hF);
        idle(1); chk(!bad_mask, "R12 all-ones accepted", {31'd0, bad_mask}, 0);
        wr(A_MASK, 32'h0000_FFFF, 4'hF);
        idle(1); chk(!bad_mask, "R12 in-range accepted", {31'd0, bad_mask}, 0);
        wr(A_MASK, 32'h0001_0000, 4'hF);
        idle(1); chk(bad_mask, "R12 out-of-range flagged", {31'd0, bad_mask}, 1);
        rd(A_MASK, v); chk(v == 32'h0001_0000, "R12 value stored", v, 32'h0001_0000);
        wr(A_MASK, 32'h0000_0001, 4'hF);
        idle(1); chk(bad_mask, "R12 flag sticky", {31'd0, bad_mask}, 1);
    endtask

    task automatic t_read_race();
        logic [31:0] v;
        wr(A_PEND, 32'h0, 4'hF);
        irq_in[7] = 1'b1;
        rd(A_PEND, v);
        irq_in[7] = 1'b0;
        chk(v == 0, "R8 read returns prior value", v, 0);
        rd(A_PEND, v); chk(v == 32'h80, "R8 same-cycle set survives", v, 32'h80);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pending();
        t_message();
        t_backpressure();
        t_bus_error();
        t_lanes();
        t_mask_flag();
        t_read_race();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule